// File: doc/BRIEF.md
# Training Lock Detector with Pattern Averaging

This block sits on the receive side of a source-synchronous parallel link. It watches the sampled word stream and its control flag, and it picks out complete training patterns. A pattern is a run of training control words followed by a run of training data words. Each training control word carries a 4-bit diagonal-parity check field. A pattern counts as good only when every control word in it passes that check.

The block does not lock on a single pattern. An external phase aligner offers a candidate sample phase on `phase_in`. The detector adds that phase into an accumulator each time a good pattern ends. When a programmed number of good patterns (2**AVG_LOG2, 32 by default) has been gathered, it commits the average as the new sample phase and pulses a one-cycle update strobe. After the first commit it raises `cal_ready`, which tells the flow-control side that the calendar may be provisioned.

Later periodic training passes go through the same full averaging count before a new phase is applied. Training may also run without end, for example during power-on, and the detector simply keeps averaging and committing. The delay-line adjustment itself is outside this block. The phase value is only carried across the interface.

Top module: `tl_lock_detect`

## Requirements
- R1: A good pattern is PAT_REPS (10) valid training control words followed directly by PAT_REPS valid training data words. A training control word has `word_ctl`=1 and `word_dat[15:4]`=12'h0F0. A training data word has `word_ctl`=0 and `word_dat`=16'h5A5A. Extra leading control words are allowed, and cycles with `word_vld`=0 are skipped without breaking the match. The pattern is counted on the edge that accepts its last data word.
- R2: Any other valid word breaks a partial match. This includes a data word before the control run is complete, a non-training word, and a control word in the middle of the data run. Such a pattern adds nothing to the count.
- R3: A training control word passes its check when the XOR of all four nibbles of `word_dat` equals 4'hF, so 16'h0F00 is good. A failing control word breaks the partial match, but it leaves `good_cnt` and the accumulator unchanged.
- R4: `good_cnt` rises by exactly one for each good pattern, and it changes only on an edge that accepts a valid word.
- R5: `lock_state` encodes 0 = searching, 1 = averaging, 2 = locked, and never takes the value 3. A good pattern that does not complete the count leaves the state at averaging.
- R6: The good pattern that brings the count to 2**AVG_LOG2 commits `phase_out` = floor(sum of the sampled `phase_in` values / 2**AVG_LOG2). The same edge pulses `phase_upd` for exactly one cycle, returns `good_cnt` to 0 and enters the locked state.
- R7: `cal_ready` stays low until the first commit. It rises together with that commit's `phase_upd` and stays high until reset.
- R8: When locked, a good pattern starts periodic re-training: the state becomes averaging with `good_cnt`=1. `phase_out` keeps its old value until the full count completes again.
- R9: An unbroken stream of good patterns keeps producing a commit every 2**AVG_LOG2 patterns, with no overflow of the count or the accumulator.
- R10: While `rst_n` is low, the outputs are: state searching, `good_cnt`=0, `phase_out`=0, and `phase_upd` and `cal_ready` both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | A sampled word is present this cycle |
| word_ctl | input | 1 | Control flag of the sampled word |
| word_dat | input | 16 | Sampled word |
| phase_in | input | 6 | Candidate sample phase from the aligner |
| phase_out | output | 6 | Committed averaged sample phase |
| phase_upd | output | 1 | One-cycle pulse when `phase_out` is committed |
| cal_ready | output | 1 | Calendar may be provisioned |
| lock_state | output | 2 | 0 searching, 1 averaging, 2 locked |
| good_cnt | output | 5 | Good patterns gathered in the current average |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe is a single-cycle pulse that lands in the locked state with a cleared count;
- `cal_ready` is sticky and rises only with a strobe;
- `phase_out` never moves without the strobe;
- the count only steps by one or returns to zero, and only after a valid word;
- the state code stays legal.

Other behaviour can only be shown by the bench's scenarios:
- which word sequences count as a pattern;
- that a failing parity check or a break leaves the count intact;
- that extra leading control words and idle gaps are tolerated;
- that the committed value is the correct average over power-on, periodic and continuous training.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_AVG    = 2'd1,
    ST_LOCK   = 2'd2
  } tl_state_e;
endpackage

// File: rtl/tl_word_classify.sv
// Decodes one sampled word into training-control / training-data flags.
module tl_word_classify #(
  parameter int               W        = 16,
  parameter logic [W-5:0]     TC_TAG   = 'h0F0,
  parameter logic [W-1:0]     TD_WORD  = 'h5A5A
) (
  input  logic         ctl,
  input  logic [W-1:0] dat,
  output logic         is_tc,
  output logic         is_td
);
  localparam int NIB = W / 4;

  logic [3:0] fold;

  always_comb begin
    fold = '0;
    for (int i = 0; i < NIB; i++) begin
      fold = fold ^ dat[i*4 +: 4];
    end
  end

  assign is_tc = ctl && (dat[W-1:4] == TC_TAG) && (fold == 4'hF);
  assign is_td = !ctl && (dat == TD_WORD);
endmodule

// File: rtl/tl_pattern_match.sv
// Tracks the control run and data run of one training pattern.
module tl_pattern_match #(
  parameter int REPS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic is_tc,
  input  logic is_td,
  output logic pat_done
);
  localparam int              RW      = $clog2(REPS + 1);
  localparam logic [RW-1:0]   REPS_V  = RW'(REPS);
  localparam logic [RW-1:0]   LAST_V  = RW'(REPS - 1);

  logic [RW-1:0] ctl_q, ctl_n;
  logic [RW-1:0] dat_q, dat_n;
  logic          done_n;

  always_comb begin
    ctl_n  = ctl_q;
    dat_n  = dat_q;
    done_n = 1'b0;
    if (vld) begin
      if (is_tc) begin
        if (dat_q == '0) begin
          if (ctl_q != REPS_V) ctl_n = ctl_q + 1'b1;
        end else begin
          ctl_n = RW'(1);
          dat_n = '0;
        end
      end else if (is_td && (ctl_q == REPS_V)) begin
        if (dat_q == LAST_V) begin
          done_n = 1'b1;
          ctl_n  = '0;
          dat_n  = '0;
        end else begin
          dat_n = dat_q + 1'b1;
        end
      end else begin
        ctl_n = '0;
        dat_n = '0;
      end
    end
  end

  assign pat_done = done_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dat_q <= '0;
    end else if (vld) begin
      ctl_q <= ctl_n;
      dat_q <= dat_n;
    end
  end
endmodule

// File: rtl/tl_phase_average.sv
// Accumulates the sampled phase over 2**AVG_LOG2 good patterns and commits it.
module tl_phase_average
  import tl_pkg::*;
#(
  parameter int PW       = 6,
  parameter int AVG_LOG2 = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pat_done,
  input  logic [PW-1:0]       phase_in,
  output logic [PW-1:0]       phase_out,
  output logic                phase_upd,
  output logic                cal_ready,
  output tl_state_e           state,
  output logic [AVG_LOG2-1:0] cnt
);
  localparam int                  SW       = PW + AVG_LOG2;
  localparam logic [AVG_LOG2-1:0] CNT_LAST = '1;

  tl_state_e           state_q, state_n;
  logic [AVG_LOG2-1:0] cnt_q, cnt_n;
  logic [SW-1:0]       sum_q, sum_n, sum_add;
  logic [PW-1:0]       phase_q, phase_n;
  logic                upd_q, upd_n;
  logic                cal_q, cal_n;

  assign sum_add = sum_q + SW'(phase_in);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sum_n   = sum_q;
    phase_n = phase_q;
    cal_n   = cal_q;
    upd_n   = 1'b0;
    if (pat_done) begin
      if (cnt_q == CNT_LAST) begin
        phase_n = sum_add[SW-1:AVG_LOG2];
        upd_n   = 1'b1;
        cal_n   = 1'b1;
        state_n = ST_LOCK;
        cnt_n   = '0;
        sum_n   = '0;
      end else begin
        cnt_n   = cnt_q + 1'b1;
        sum_n   = sum_add;
        state_n = ST_AVG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      cnt_q   <= '0;
      sum_q   <= '0;
      phase_q <= '0;
      cal_q   <= 1'b0;
    end else if (pat_done) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sum_q   <= sum_n;
      phase_q <= phase_n;
      cal_q   <= cal_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_n;
  end

  assign phase_out = phase_q;
  assign phase_upd = upd_q;
  assign cal_ready = cal_q;
  assign state     = state_q;
  assign cnt       = cnt_q;
endmodule

// File: rtl/tl_lock_detect.sv
// Training lock detector: pattern recognition plus averaged phase commit.
module tl_lock_detect
  import tl_pkg::*;
#(
  parameter int W        = 16,
  parameter int PAT_REPS = 10,
  parameter int AVG_LOG2 = 5,
  parameter int PW       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_vld,
  input  logic                word_ctl,
  input  logic [W-1:0]        word_dat,
  input  logic [PW-1:0]       phase_in,
  output logic [PW-1:0]       phase_out,
  output logic                phase_upd,
  output logic                cal_ready,
  output logic [1:0]          lock_state,
  output logic [AVG_LOG2-1:0] good_cnt
);
  logic      is_tc, is_td, pat_done;
  tl_state_e st;

  tl_word_classify #(.W(W)) u_cls (
    .ctl   (word_ctl),
    .dat   (word_dat),
    .is_tc (is_tc),
    .is_td (is_td)
  );

  tl_pattern_match #(.REPS(PAT_REPS)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld      (word_vld),
    .is_tc    (is_tc),
    .is_td    (is_td),
    .pat_done (pat_done)
  );

  tl_phase_average #(.PW(PW), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat_done  (pat_done),
    .phase_in  (phase_in),
    .phase_out (phase_out),
    .phase_upd (phase_upd),
    .cal_ready (cal_ready),
    .state     (st),
    .cnt       (good_cnt)
  );

  assign lock_state = st;
endmodule

// File: rtl/tl_lock_detect_chk.sv
module tl_lock_detect_chk #(
  parameter int AVG_LOG2 = 5,
  parameter int PW       = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                word_vld,
  input logic [PW-1:0]       phase_out,
  input logic                phase_upd,
  input logic                cal_ready,
  input logic [1:0]          lock_state,
  input logic [AVG_LOG2-1:0] good_cnt
);
  // R6: strobe lasts one cycle
  a_r6_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
    phase_upd |=> !phase_upd);

  // R6: strobe coincides with locked state and cleared count
  a_r6_upd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    phase_upd |-> (lock_state == 2'd2 && good_cnt == '0));

  // R7: calendar permission is sticky
  a_r7_cal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ready |=> cal_ready);

  // R7: calendar permission rises only with a commit
  a_r7_cal_with_upd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_ready) |-> phase_upd);

  // R8: committed phase moves only with the strobe
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_upd |-> $stable(phase_out));

  // R4: count steps by one or wraps to zero
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(good_cnt) |-> (good_cnt == $past(good_cnt) + 1'b1 || good_cnt == '0));

  // R4: count changes only after a valid word
  a_r4_cnt_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(good_cnt) |-> $past(word_vld));

  // R5: state code legal
  a_r5_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state != 2'd3);
endmodule

bind tl_lock_detect tl_lock_detect_chk #(.AVG_LOG2(AVG_LOG2), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_vld   (word_vld),
  .phase_out  (phase_out),
  .phase_upd  (phase_upd),
  .cal_ready  (cal_ready),
  .lock_state (lock_state),
  .good_cnt   (good_cnt)
);

// File: tb/sim_tl_lock_detect.sv
`timescale 1ns/100ps
module sim_tl_lock_detect;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_vld, word_ctl;
  logic [15:0] word_dat;
  logic [5:0]  phase_in, phase_out;
  logic        phase_upd, cal_ready;
  logic [1:0]  lock_state;
  logic [4:0]  good_cnt;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int exp_cnt = 0, exp_sum = 0, exp_phase = 0, exp_state = 0, exp_cal = 0;

  always #2.5 clk = ~clk;

  tl_lock_detect u0 (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_ctl(word_ctl),
    .word_dat(word_dat), .phase_in(phase_in), .phase_out(phase_out),
    .phase_upd(phase_upd), .cal_ready(cal_ready), .lock_state(lock_state),
    .good_cnt(good_cnt)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(bit v, bit c, logic [15:0] d);
    word_vld = v; word_ctl = c; word_dat = d;
    @(negedge clk);
  endtask

  task automatic check_all(bit upd);
    check("R4 good_cnt", int'(good_cnt), exp_cnt);
    check("R5 lock_state", int'(lock_state), exp_state);
    check("R7 cal_ready", int'(cal_ready), exp_cal);
    check("R6 phase_upd", int'(phase_upd), int'(upd));
    check("R8 phase_out", int'(phase_out), exp_phase);
  endtask

  // R1: full good pattern with optional extra control words and idle gaps
  task automatic good_pat(int ph, int nctl, bit gap);
    bit commit;
    phase_in = 6'(ph);
    for (int i = 0; i < nctl; i++) begin
      send(1'b1, 1'b1, 16'h0F00);
      if (gap) send(1'b0, 1'b0, 16'h0000);
    end
    for (int i = 0; i < 10; i++) begin
      send(1'b1, 1'b0, 16'h5A5A);
      if (gap && i != 9) send(1'b0, 1'b0, 16'h0000);
    end
    commit = (exp_cnt == N - 1);
    exp_sum += ph;
    if (commit) begin
      exp_phase = (exp_sum / N) % 64;
      exp_sum = 0; exp_cnt = 0; exp_state = 2; exp_cal = 1;
    end else begin
      exp_cnt++; exp_state = 1;
    end
    check_all(commit);
    if (commit) begin
      send(1'b0, 1'b0, 16'h0000);
      check("R6 strobe one cycle", int'(phase_upd), 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; word_vld = 0; word_ctl = 0; word_dat = 0; phase_in = 6'd63;
    repeat (3) @(negedge clk);
    check("R10 state", int'(lock_state), 0);
    check("R10 cnt", int'(good_cnt), 0);
    check("R10 phase", int'(phase_out), 0);
    check("R10 upd", int'(phase_upd), 0);
    check("R10 cal", int'(cal_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic();
    good_pat(7, 10, 0);   // R1 plain pattern
    good_pat(9, 14, 0);   // R1 extra leading control words
    good_pat(11, 10, 1);  // R1 idle gaps
  endtask

  task automatic t_break();
    // R2: non-training word in the data run
    for (int i = 0; i < 10; i++) send(1, 1, 16'h0F00);
    for (int i = 0; i < 5; i++) send(1, 0, 16'h5A5A);
    send(1, 0, 16'h1234);
    for (int i = 0; i < 5; i++) send(1, 0, 16'h5A5A);
    check("R2 break by other word", int'(good_cnt), exp_cnt);
    // R2: short control run
    for (int i = 0; i < 9; i++) send(1, 1, 16'h0F00);
    for (int i = 0; i < 10; i++) send(1, 0, 16'h5A5A);
    check("R2 short control run", int'(good_cnt), exp_cnt);
    // R2: control word inside data run
    for (int i = 0; i < 10; i++) send(1, 1, 16'h0F00);
    for (int i = 0; i < 4; i++) send(1, 0, 16'h5A5A);
    send(1, 1, 16'h0F00);
    for (int i = 0; i < 6; i++) send(1, 0, 16'h5A5A);
    check("R2 control in data run", int'(good_cnt), exp_cnt);
    check("R2 state held", int'(lock_state), exp_state);
  endtask

  task automatic t_dip();
    // R3: check nibble wrong in one control word
    for (int i = 0; i < 5; i++) send(1, 1, 16'h0F00);
    send(1, 1, 16'h0F03);
    for (int i = 0; i < 4; i++) send(1, 1, 16'h0F00);
    for (int i = 0; i < 10; i++) send(1, 0, 16'h5A5A);
    check("R3 bad parity not counted", int'(good_cnt), exp_cnt);
    // R3: ten bad control words
    for (int i = 0; i < 10; i++) send(1, 1, 16'h0F0F);
    for (int i = 0; i < 10; i++) send(1, 0, 16'h5A5A);
    check("R3 all bad not counted", int'(good_cnt), exp_cnt);
    // R3: count survives, next good pattern adds one
    good_pat(13, 10, 0);
  endtask

  task automatic t_lock();
    int k = 0;
    while (exp_state != 2) begin
      good_pat((k * 5 + 20) % 64, 10, 0);
      k++;
    end
  endtask

  task automatic t_retrain();
    int held = exp_phase;
    good_pat(60, 10, 0);
    check("R8 retrain state", int'(lock_state), 1);
    check("R8 retrain cnt", int'(good_cnt), 1);
    check("R8 phase held", int'(phase_out), held);
    check("R7 cal held", int'(cal_ready), 1);
    for (int i = 0; i < N - 1; i++) good_pat(58 + (i % 4), 10, 0);
    check("R8 retrain committed", int'(lock_state), 2);
  endtask

  task automatic t_stream();
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) good_pat((r * 17 + i * 3) % 64, 10, 0);
      check("R9 commit each block", int'(lock_state), 2);
    end
    for (int i = 0; i < N; i++) good_pat(63, 10, 0);
    check("R9 max phase no overflow", int'(phase_out), 63);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_break();
    t_dip();
    t_lock();
    t_retrain();
    t_stream();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule